// File: doc/BRIEF.md
# Fan Tachometer Period Monitor

This block watches the pulse train a cooling fan returns on its tachometer line and turns it into a speed figure. Each period is counted in clock cycles, from one rising edge to the next. A power-of-two number of consecutive periods is averaged, and each average is published with a one-cycle strobe. The block then decides whether the fan is healthy.

The health check compares each average with an acceptance window of nominal minus tolerance up to nominal plus tolerance. By default the window is taken from a per-level table. A small duty-level code selects the entry, and a code of zero means the fan is commanded off, so nothing is checked. When a custom duty is in force, firmware supplies its own window instead. That window only arms once its tolerance value has been written, and the period value has to be written before the tolerance.

Alongside the window check, a stall timer raises the error when no rising edge arrives for a long time. The error output is a single-cycle pulse meant to feed an interrupt collector.

Top module: `tacho_period_monitor`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `meas` is 0 and neither `meas_done` nor `tacho_err` is asserted.
- R2: The tacho input passes through a two-stage synchronizer. The first rising edge after reset only starts timing. After that, each group of 2^AVG_POW consecutive rising-edge-to-rising-edge periods, counted in clock cycles, is summed and shifted right by AVG_POW, which truncates. The result is loaded into `meas` in the same cycle that `meas_done` pulses high for exactly one cycle. `meas` holds its value at all other times.
- R3: Level codes 1, 2, 3 and 4 stand for 25, 50, 75 and 100 percent duty. They select table slot 0, 1, 2 and 3 of `nom_tbl`/`tol_tbl`, where slot k is bits [32k+31:32k]. When `custom_en` is low, a published average outside the inclusive range [nom−tol, nom+tol] raises `tacho_err` for one cycle, in the cycle after `meas_done`. If tol exceeds nom, the lower bound is 0.
- R4: With level code 0, or any code above 4, and `custom_en` low, no error is raised by either the window check or the stall timer. Measurements are still published.
- R5: While checking is enabled, STALL_CYCLES consecutive cycles without a synchronized rising edge raise `tacho_err` for one cycle. It does not fire again until a rising edge has been seen.
- R6: While `custom_en` is high, the software window replaces the table. `sw_wr_period` loads the nominal from `sw_value` and disarms. `sw_wr_tol` loads the tolerance and arms only if a period write came earlier in this custom session. While custom mode is unarmed, neither the window check nor the stall timer can raise `tacho_err`. Dropping `custom_en` discards the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tacho_in | input | 1 | Raw, asynchronous tachometer line |
| duty_lvl | input | 3 | Current duty level code (0 off, 1..4 = 25..100 percent) |
| nom_tbl | input | 128 | Four 32-bit nominal periods, slot k at [32k+31:32k] |
| tol_tbl | input | 128 | Four 32-bit tolerances, same layout |
| custom_en | input | 1 | Custom duty in force; use the software window |
| sw_wr_period | input | 1 | Strobe: load software nominal from sw_value |
| sw_wr_tol | input | 1 | Strobe: load software tolerance from sw_value and arm |
| sw_value | input | 32 | Data for the software window strobes |
| meas | output | 32 | Latest averaged period in clock cycles |
| meas_done | output | 1 | One-cycle strobe when meas is updated |
| tacho_err | output | 1 | One-cycle fault pulse (window miss or stall) |

## Verification
The hardest state to reach is an armed software window whose average falls outside the range, because getting there takes the right order of strobes plus a change of fan speed. The stimulus gets there in stages. First it writes only a tolerance, which must not arm. Then it writes period and tolerance in order, and checks that a matching speed stays quiet. Next it changes the tacho period, discards the average that mixes the old and new speeds, and expects the fault on the following one. Finally a lone period write must disarm the window again. The averaging arithmetic is exercised with hand-built sequences of unequal periods, where the sum does not divide evenly and the truncated value is known.

// File: rtl/tach_pkg.sv
package tach_pkg;

    localparam int TACH_CNT_W = 32;
    localparam int TACH_LVLS  = 4;

    typedef logic [TACH_CNT_W-1:0] tcount_t;

    typedef enum logic [2:0] {
        DUTY_OFF = 3'd0,
        DUTY_25  = 3'd1,
        DUTY_50  = 3'd2,
        DUTY_75  = 3'd3,
        DUTY_100 = 3'd4
    } duty_e;

    typedef struct packed {
        tcount_t nom;
        tcount_t tol;
    } window_t;

    // Default nominal fan periods in 10 ns cycles, per table slot.
    function automatic tcount_t def_nominal(input int slot);
        case (slot)
            0:       def_nominal = tcount_t'(1470000);
            1:       def_nominal = tcount_t'(820000);
            2:       def_nominal = tcount_t'(480000);
            default: def_nominal = tcount_t'(340000);
        endcase
    endfunction

    // Default tolerance: a percentage of the nominal.
    function automatic tcount_t def_tolerance(input int slot, input int pct);
        def_tolerance = tcount_t'((64'(def_nominal(slot)) * 64'(pct)) / 64'd100);
    endfunction

    // Inclusive acceptance test: nom - tol <= v <= nom + tol.
    function automatic logic in_window(input tcount_t v, input window_t w);
        logic [TACH_CNT_W:0] hi;
        tcount_t             lo;
        lo = (w.tol > w.nom) ? '0 : (w.nom - w.tol);
        hi = {1'b0, w.nom} + {1'b0, w.tol};
        in_window = (v >= lo) && ({1'b0, v} <= hi);
    endfunction

endpackage

// File: rtl/tach_sync_edge.sv
module tach_sync_edge (
    input  logic clk,
    input  logic rst,
    input  logic raw_in,
    output logic rise
);
    logic [2:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= '0;
        end else begin
            stage_q <= {stage_q[1:0], raw_in};
        end
    end

    // stage 0/1 synchronize, stage 2 holds the previous synchronized value
    assign rise = stage_q[1] & ~stage_q[2];
endmodule

// File: rtl/tach_period_avg.sv
module tach_period_avg
    import tach_pkg::*;
#(
    parameter int AVG_POW = 7
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    rise,
    output tcount_t avg,
    output logic    done
);
    localparam int ACC_W = TACH_CNT_W + AVG_POW;
    localparam int IDX_W = (AVG_POW > 0) ? AVG_POW : 1;
    localparam int GROUP = 1 << AVG_POW;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(GROUP - 1);

    logic              started_q;
    tcount_t           run_q;
    logic [ACC_W-1:0]  acc_q;
    logic [IDX_W-1:0]  idx_q;
    logic [ACC_W-1:0]  sum;

    assign sum = acc_q + ACC_W'(run_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            started_q <= 1'b0;
            run_q     <= '0;
            acc_q     <= '0;
            idx_q     <= '0;
            avg       <= '0;
            done      <= 1'b0;
        end else begin
            done <= 1'b0;
            if (rise) begin
                run_q <= tcount_t'(1);
                if (!started_q) begin
                    started_q <= 1'b1;
                end else if (idx_q == LAST_IDX) begin
                    avg   <= tcount_t'(sum >> AVG_POW);
                    done  <= 1'b1;
                    acc_q <= '0;
                    idx_q <= '0;
                end else begin
                    acc_q <= sum;
                    idx_q <= idx_q + 1'b1;
                end
            end else if (run_q != '1) begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/tach_window_chk.sv
module tach_window_chk
    import tach_pkg::*;
#(
    parameter int STALL_CYCLES = 500_000_000
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [2:0]                        duty_lvl,
    input  logic [TACH_LVLS*TACH_CNT_W-1:0]   nom_tbl,
    input  logic [TACH_LVLS*TACH_CNT_W-1:0]   tol_tbl,
    input  logic                              custom_en,
    input  logic                              sw_wr_period,
    input  logic                              sw_wr_tol,
    input  tcount_t                           sw_value,
    input  tcount_t                           avg,
    input  logic                              done,
    input  logic                              rise,
    output logic                              err,
    output logic                              armed
);
    localparam int STALL_W = $clog2(STALL_CYCLES + 1);
    localparam logic [STALL_W-1:0] STALL_LAST = STALL_W'(STALL_CYCLES - 1);

    window_t            lvl_win [TACH_LVLS];
    window_t            sw_win_q;
    window_t            sel_win;
    logic               period_seen_q;
    logic               chk_en;
    logic [1:0]         slot;
    logic [STALL_W-1:0] stall_q;
    logic               stall_fired_q;
    duty_e              lvl;

    for (genvar k = 0; k < TACH_LVLS; k++) begin : g_unpack
        assign lvl_win[k].nom = nom_tbl[k*TACH_CNT_W +: TACH_CNT_W];
        assign lvl_win[k].tol = tol_tbl[k*TACH_CNT_W +: TACH_CNT_W];
    end

    always_comb begin
        lvl  = duty_e'(duty_lvl);
        slot = 2'(duty_lvl - 3'd1);
        if (custom_en) begin
            chk_en  = armed;
            sel_win = sw_win_q;
        end else begin
            chk_en  = (lvl != DUTY_OFF) && (duty_lvl <= 3'(DUTY_100));
            sel_win = lvl_win[slot];
        end
    end

    // Software window: period first, then tolerance arms it.
    always_ff @(posedge clk) begin
        if (rst) begin
            sw_win_q      <= '0;
            period_seen_q <= 1'b0;
            armed         <= 1'b0;
        end else if (!custom_en) begin
            period_seen_q <= 1'b0;
            armed         <= 1'b0;
        end else if (sw_wr_period) begin
            sw_win_q.nom  <= sw_value;
            period_seen_q <= 1'b1;
            armed         <= 1'b0;
        end else if (sw_wr_tol) begin
            sw_win_q.tol  <= sw_value;
            armed         <= period_seen_q;
        end
    end

    // Window miss and stall timeout share the single error pulse.
    always_ff @(posedge clk) begin
        if (rst) begin
            err           <= 1'b0;
            stall_q       <= '0;
            stall_fired_q <= 1'b0;
        end else begin
            err <= 1'b0;
            if (done && chk_en && !in_window(avg, sel_win)) begin
                err <= 1'b1;
            end
            if (rise || !chk_en) begin
                stall_q       <= '0;
                stall_fired_q <= 1'b0;
            end else if (!stall_fired_q) begin
                if (stall_q == STALL_LAST) begin
                    err           <= 1'b1;
                    stall_fired_q <= 1'b1;
                end else begin
                    stall_q <= stall_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/tacho_period_monitor.sv
module tacho_period_monitor
    import tach_pkg::*;
#(
    parameter int AVG_POW      = 7,
    parameter int STALL_CYCLES = 500_000_000
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             tacho_in,
    input  logic [2:0]                       duty_lvl,
    input  logic [TACH_LVLS*TACH_CNT_W-1:0]  nom_tbl,
    input  logic [TACH_LVLS*TACH_CNT_W-1:0]  tol_tbl,
    input  logic                             custom_en,
    input  logic                             sw_wr_period,
    input  logic                             sw_wr_tol,
    input  logic [TACH_CNT_W-1:0]            sw_value,
    output logic [TACH_CNT_W-1:0]            meas,
    output logic                             meas_done,
    output logic                             tacho_err
);
    initial begin
        if (AVG_POW < 0 || AVG_POW > 7) $error("AVG_POW must lie in 0..7");
        if (STALL_CYCLES < 2) $error("STALL_CYCLES must be at least 2");
    end

    logic    rise;
    logic    sw_armed;
    tcount_t avg;

    tach_sync_edge u_sync (
        .clk    (clk),
        .rst    (rst),
        .raw_in (tacho_in),
        .rise   (rise)
    );

    tach_period_avg #(.AVG_POW(AVG_POW)) u_avg (
        .clk  (clk),
        .rst  (rst),
        .rise (rise),
        .avg  (avg),
        .done (meas_done)
    );

    tach_window_chk #(.STALL_CYCLES(STALL_CYCLES)) u_win (
        .clk          (clk),
        .rst          (rst),
        .duty_lvl     (duty_lvl),
        .nom_tbl      (nom_tbl),
        .tol_tbl      (tol_tbl),
        .custom_en    (custom_en),
        .sw_wr_period (sw_wr_period),
        .sw_wr_tol    (sw_wr_tol),
        .sw_value     (sw_value),
        .avg          (avg),
        .done         (meas_done),
        .rise         (rise),
        .err          (tacho_err),
        .armed        (sw_armed)
    );

    assign meas = avg;
endmodule

// File: rtl/tach_mon_checker.sv
module tach_mon_checker (
    input logic        clk,
    input logic        rst,
    input logic [2:0]  duty_lvl,
    input logic        custom_en,
    input logic        armed,
    input logic [31:0] meas,
    input logic        meas_done,
    input logic        tacho_err
);
    assert_reset_quiet_R1: assert property (@(posedge clk)
        $past(rst) |-> (meas == 32'd0 && !meas_done && !tacho_err));

    assert_done_single_R2: assert property (@(posedge clk) disable iff (rst)
        meas_done |=> !meas_done);

    assert_meas_held_R2: assert property (@(posedge clk) disable iff (rst)
        !meas_done |-> $stable(meas));

    assert_off_no_err_R4: assert property (@(posedge clk) disable iff (rst)
        (!custom_en && (duty_lvl == 3'd0 || duty_lvl > 3'd4)) |=> !tacho_err);

    assert_unarmed_no_err_R6: assert property (@(posedge clk) disable iff (rst)
        (custom_en && !armed) |=> !tacho_err);

    assert_err_single_R5: assert property (@(posedge clk) disable iff (rst)
        (tacho_err && !meas_done) |=> !tacho_err);
endmodule

bind tacho_period_monitor tach_mon_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .duty_lvl  (duty_lvl),
    .custom_en (custom_en),
    .armed     (sw_armed),
    .meas      (meas),
    .meas_done (meas_done),
    .tacho_err (tacho_err)
);

// File: tb/tacho_period_monitor_tb_top.sv
module tacho_period_monitor_tb_top;
    localparam int AVG_POW = 2;
    localparam int STALL   = 5000;
    localparam int NVEC    = 9;

    localparam logic [2:0] VEC_LVL [NVEC] = '{3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd3, 3'd4, 3'd0, 3'd4};
    localparam int         VEC_PER [NVEC] = '{400, 520, 250, 251, 90, 89, 80, 300, 200};
    localparam bit         VEC_ERR [NVEC] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1};

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         tacho_in = 1'b0;
    logic [2:0]   duty_lvl = 3'd0;
    logic [127:0] nom_tbl;
    logic [127:0] tol_tbl;
    logic         custom_en = 1'b0;
    logic         sw_wr_period = 1'b0;
    logic         sw_wr_tol = 1'b0;
    logic [31:0]  sw_value = '0;
    logic [31:0]  meas;
    logic         meas_done;
    logic         tacho_err;

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;
    int err_cnt = 0;
    int tach_per = 0;
    int tcnt = 0;
    logic [31:0] last_meas = '0;

    // slots 25/50/75/100 percent: nominal and 25 percent tolerance
    assign nom_tbl = {32'd80, 32'd120, 32'd200, 32'd400};
    assign tol_tbl = {32'd20, 32'd30,  32'd50,  32'd100};

    always #2.5 clk = ~clk;

    tacho_period_monitor #(.AVG_POW(AVG_POW), .STALL_CYCLES(STALL)) dut_i (
        .clk          (clk),
        .rst          (rst),
        .tacho_in     (tacho_in),
        .duty_lvl     (duty_lvl),
        .nom_tbl      (nom_tbl),
        .tol_tbl      (tol_tbl),
        .custom_en    (custom_en),
        .sw_wr_period (sw_wr_period),
        .sw_wr_tol    (sw_wr_tol),
        .sw_value     (sw_value),
        .meas         (meas),
        .meas_done    (meas_done),
        .tacho_err    (tacho_err)
    );

    // free-running square-wave generator, active when tach_per != 0
    initial forever begin
        @(negedge clk);
        if (tach_per != 0) begin
            tacho_in = (tcnt < tach_per / 2);
            tcnt = (tcnt + 1 >= tach_per) ? 0 : tcnt + 1;
        end else begin
            tcnt = 0;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (meas_done) begin
                done_cnt  = done_cnt + 1;
                last_meas = meas;
            end
            if (tacho_err) err_cnt = err_cnt + 1;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        tach_per = 0;
        tacho_in = 1'b0;
        custom_en = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        done_cnt = 0;
        err_cnt = 0;
    endtask

    task automatic wait_done(input int n);
        int guard = 0;
        while (done_cnt < n && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic sw_write(input bit is_tol, input int value);
        @(negedge clk);
        sw_value = 32'(value);
        if (is_tol) sw_wr_tol = 1'b1; else sw_wr_period = 1'b1;
        @(negedge clk);
        sw_wr_tol = 1'b0;
        sw_wr_period = 1'b0;
    endtask

    task automatic pulse(input int p);
        tacho_in = 1'b1;
        repeat (p / 2) @(negedge clk);
        tacho_in = 1'b0;
        repeat (p - p / 2) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors = errors + 1;
        checks = checks + 1;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        // R1: outputs quiet in reset
        repeat (3) @(negedge clk);
        check(meas == 0 && !meas_done && !tacho_err, "R1", longint'(meas), 0);
        do_reset();
        check(meas == 0 && done_cnt == 0 && err_cnt == 0, "R1", longint'(meas), 0);

        // R2/R3/R4: table walk of level and steady tacho period
        for (int i = 0; i < NVEC; i++) begin
            do_reset();
            duty_lvl = VEC_LVL[i];
            tach_per = VEC_PER[i];
            wait_done(1);
            check(last_meas == 32'(VEC_PER[i]), "R2", longint'(last_meas), VEC_PER[i]);
            check((err_cnt != 0) == VEC_ERR[i], (VEC_LVL[i] == 3'd0) ? "R4" : "R3",
                  err_cnt, VEC_ERR[i]);
        end

        // R2: average of unequal periods, exact
        do_reset();
        duty_lvl = 3'd0;
        pulse(100); pulse(100); pulse(200); pulse(200); pulse(40);
        wait_done(1);
        check(last_meas == 32'd150, "R2", longint'(last_meas), 150);
        check(done_cnt == 1, "R2", done_cnt, 1);

        // R2: truncating average (403 / 4 = 100)
        do_reset();
        pulse(100); pulse(101); pulse(101); pulse(101); pulse(40);
        wait_done(1);
        check(last_meas == 32'd100, "R2", longint'(last_meas), 100);

        // R5: stall fires once while checking
        do_reset();
        duty_lvl = 3'd2;
        repeat (STALL + 20) @(negedge clk);
        check(err_cnt == 1, "R5", err_cnt, 1);
        repeat (STALL + 20) @(negedge clk);
        check(err_cnt == 1, "R5", err_cnt, 1);

        // R4: no stall error with fan off
        do_reset();
        duty_lvl = 3'd0;
        repeat (STALL + 20) @(negedge clk);
        check(err_cnt == 0, "R4", err_cnt, 0);

        // R6: custom window
        do_reset();
        duty_lvl = 3'd1;
        custom_en = 1'b1;
        tach_per = 520;
        wait_done(1);
        check(err_cnt == 0, "R6", err_cnt, 0);
        sw_write(1'b1, 20);
        wait_done(3);
        check(err_cnt == 0, "R6", err_cnt, 0);
        sw_write(1'b0, 520);
        sw_write(1'b1, 20);
        done_cnt = 0;
        wait_done(2);
        check(err_cnt == 0, "R6", err_cnt, 0);
        check(last_meas == 32'd520, "R6", longint'(last_meas), 520);
        tach_per = 600;
        done_cnt = 0;
        wait_done(1);
        err_cnt = 0;
        done_cnt = 0;
        wait_done(1);
        check(err_cnt == 1, "R6", err_cnt, 1);
        sw_write(1'b0, 600);
        err_cnt = 0;
        done_cnt = 0;
        wait_done(2);
        check(err_cnt == 0, "R6", err_cnt, 0);

        finish_run();
    end
endmodule